// File: doc/BRIEF.md
# Event Buffer and Slave Register File for a Multichannel Charge Converter

This block is the bus-facing side of an eight-channel, dual-range charge-integrating converter. The conversion sequencer hands it one 16-bit result word per cycle. The block queues these words in a first-in first-out store sized for sixteen complete events: 8 channels times 2 ranges, which is 256 words. A 16-bit slave port with a strobe and a one-cycle acknowledge gives software access to a small register map. Through it, software can read the queue and its flags, program an interrupt level and vector, load a test DAC, fire a test gate, clear the module, and read an identification word.

The interrupt request is a level output. It is non-zero only while the programmed level is non-zero and the chosen queue condition holds. A static configuration input picks that condition: queue not empty, or queue full. The request falls in the same cycle as the condition, so it is released by the register access that drains the queue and needs no acknowledge cycle. A clear, either from the bus or from a dedicated input, empties the queue and zeroes the programmable registers. It also sends a one-cycle pulse to the integrators.

Top module: `evb_regfile`

## Requirements
- R1: An access starts on a rising clock edge where busStb is 1 and busAck is 0. busAck is 1 for exactly the following cycle, and busRdata holds the read result during that cycle.
- R2: Each cycle with wordValid high pushes wordData, as long as fewer than 256 words are queued. Words offered while 256 are queued are dropped.
- R3: A read at byte offset 08h returns the oldest queued word and removes it. A read there while the queue is empty returns the value that the previous read at 08h returned (0 after reset) and removes nothing. A write at 08h changes nothing.
- R4: Offset 00h reads as {ready, full, 3'b000, level[2:0], vector[7:0]}. Bit 15 (ready) is 1 while the queue holds at least one word, and bit 14 (full) is 1 while it holds 256. A write at 00h stores bits 10:8 as the level and bits 7:0 as the vector, and ignores bits 15:11.
- R5: irqLevel equals the stored level when that level is non-zero and the selected condition holds; otherwise it is 0. The condition is "not empty" when trigOnFull is 0 and "full" when trigOnFull is 1. irqVector always shows the stored vector.
- R6: irqLevel returns to 0 in the same cycle that the selected condition becomes false, such as after the read that empties or un-fills the queue.
- R7: Any clear empties the queue and zeroes the level, the vector and the DAC register, and drives clearPulse high for the next cycle. A clear is either a read or write access at offset 02h, or extClear high at a clock edge.
- R8: A write at offset 04h stores busWdata[11:0] on dacLevel. A read at 04h returns 0.
- R9: Any read or write access at offset 06h drives testGate high for exactly one cycle, the acknowledge cycle.
- R10: A read at the top offset (FEh with the default address width) returns {3'b000, variantSel, serialNum}.
- R11: Unmapped offsets read as 0, and writes to them change no output or register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| busStb | input | 1 | Access strobe |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte offset within the block |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data, valid with busAck |
| busAck | output | 1 | One-cycle acknowledge |
| wordValid | input | 1 | Sequencer result word present |
| wordData | input | 16 | Sequencer result word |
| extClear | input | 1 | Synchronous external clear |
| trigOnFull | input | 1 | Interrupt condition: 0 not empty, 1 full |
| variantSel | input | 1 | Signalling variant shown in the identification word |
| serialNum | input | 12 | Serial number shown in the identification word |
| irqLevel | output | 3 | Requested interrupt level, 0 = none |
| irqVector | output | 8 | Interrupt vector |
| dacLevel | output | 12 | Test DAC code |
| testGate | output | 1 | One-shot internal test gate |
| clearPulse | output | 1 | One-cycle reset to the integrators |

## Verification
The properties assume that every input changes only between clock edges and that extClear is already synchronous to clk. They also assume that busStb is held for no more than one cycle per access, so a strobe is never still high during its own acknowledge. The bench drives all inputs on the falling edge and raises busStb for one cycle per access, which keeps within these limits. It offers sequencer words only when no status read is in flight, so each expected status word reflects a settled queue.

// File: rtl/evb_pkg.sv
package evb_pkg;
  localparam int WORD_W   = 16;
  localparam int LEVEL_W  = 3;
  localparam int VEC_W    = 8;
  localparam int DAC_W    = 12;
  localparam int SERIAL_W = 12;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STAT,
    SEL_DAC,
    SEL_DATA,
    SEL_ID
  } rdSel_e;

  typedef struct packed {
    logic   access;
    logic   pop;
    logic   clear;
    logic   statWr;
    logic   dacWr;
    rdSel_e rdSel;
  } ctlStrobe_t;
endpackage

// File: rtl/evb_ctrl.sv
module evb_ctrl
  import evb_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busStb,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              extClear,
  output ctlStrobe_t        str,
  output logic              busAck,
  output logic              testGate,
  output logic              clearPulse
);
  localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] OFF_CLR  = ADDR_W'(8'h02);
  localparam logic [ADDR_W-1:0] OFF_DAC  = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] OFF_GATE = ADDR_W'(8'h06);
  localparam logic [ADDR_W-1:0] OFF_DATA = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] OFF_ID   = {{(ADDR_W-1){1'b1}}, 1'b0};

  logic acc;
  logic fire;

  assign acc = busStb && !busAck;

  always_comb begin
    str        = '0;
    str.rdSel  = SEL_NONE;
    str.access = acc;
    str.clear  = extClear || (acc && busAddr == OFF_CLR);
    fire       = acc && busAddr == OFF_GATE;
    if (acc) begin
      unique case (busAddr)
        OFF_STAT: begin
          str.statWr = busWe;
          str.rdSel  = busWe ? SEL_NONE : SEL_STAT;
        end
        OFF_DAC:  str.dacWr = busWe;
        OFF_DATA: begin
          str.pop   = !busWe;
          str.rdSel = busWe ? SEL_NONE : SEL_DATA;
        end
        OFF_ID:   str.rdSel = busWe ? SEL_NONE : SEL_ID;
        default:  str.rdSel = SEL_NONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busAck     <= 1'b0;
      testGate   <= 1'b0;
      clearPulse <= 1'b0;
    end else begin
      busAck     <= acc;
      testGate   <= fire;
      clearPulse <= str.clear;
    end
  end
endmodule

// File: rtl/evb_data.sv
module evb_data
  import evb_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobe_t          str,
  input  logic [WORD_W-1:0]   busWdata,
  input  logic                wordValid,
  input  logic [WORD_W-1:0]   wordData,
  input  logic                trigOnFull,
  input  logic                variantSel,
  input  logic [SERIAL_W-1:0] serialNum,
  output logic [WORD_W-1:0]   busRdata,
  output logic                fifoRdy,
  output logic                fifoFull,
  output logic [LEVEL_W-1:0]  irqLevel,
  output logic [VEC_W-1:0]    irqVector,
  output logic [DAC_W-1:0]    dacLevel
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

  logic [WORD_W-1:0]  mem [DEPTH];
  logic [PTR_W-1:0]   wrPtr, rdPtr;
  logic [CNT_W-1:0]   count;
  logic [LEVEL_W-1:0] levelQ;
  logic [VEC_W-1:0]   vectorQ;
  logic [WORD_W-1:0]  lastRead;
  logic [WORD_W-1:0]  dataWord;
  logic [WORD_W-1:0]  rdValue;
  logic               pushOk, popOk, condNow;
  logic [WORD_W-1:0]  unusedBits;

  assign unusedBits = {busWdata[15:11], 11'b0};

  assign fifoRdy  = count != '0;
  assign fifoFull = count == CNT_MAX;
  assign pushOk   = wordValid && !fifoFull;
  assign popOk    = str.pop && fifoRdy;
  assign dataWord = fifoRdy ? mem[rdPtr] : lastRead;

  always_comb begin
    unique case (str.rdSel)
      SEL_STAT: rdValue = {fifoRdy, fifoFull, 3'b000, levelQ, vectorQ};
      SEL_DATA: rdValue = dataWord;
      SEL_ID:   rdValue = {3'b000, variantSel, serialNum};
      default:  rdValue = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (pushOk) mem[wrPtr] <= wordData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      count    <= '0;
      levelQ   <= '0;
      vectorQ  <= '0;
      dacLevel <= '0;
      lastRead <= '0;
      busRdata <= '0;
    end else begin
      if (str.access) busRdata <= rdValue;
      if (str.rdSel == SEL_DATA) lastRead <= dataWord;
      if (str.clear) begin
        wrPtr    <= '0;
        rdPtr    <= '0;
        count    <= '0;
        levelQ   <= '0;
        vectorQ  <= '0;
        dacLevel <= '0;
      end else begin
        if (pushOk) wrPtr <= wrPtr + 1'b1;
        if (popOk)  rdPtr <= rdPtr + 1'b1;
        count <= count + CNT_W'(pushOk) - CNT_W'(popOk);
        if (str.statWr) begin
          levelQ  <= busWdata[10:8];
          vectorQ <= busWdata[7:0];
        end
        if (str.dacWr) dacLevel <= busWdata[DAC_W-1:0];
      end
    end
  end

  // interrupt follows the selected flag combinationally so it drops with it
  assign condNow   = trigOnFull ? fifoFull : fifoRdy;
  assign irqLevel  = (levelQ != '0 && condNow) ? levelQ : '0;
  assign irqVector = vectorQ;
endmodule

// File: rtl/evb_regfile.sv
module evb_regfile
  import evb_pkg::*;
#(
  parameter int EVENTS   = 16,
  parameter int CHANNELS = 8,
  parameter int RANGES   = 2,
  parameter int ADDR_W   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busStb,
  input  logic                busWe,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [WORD_W-1:0]   busWdata,
  output logic [WORD_W-1:0]   busRdata,
  output logic                busAck,
  input  logic                wordValid,
  input  logic [WORD_W-1:0]   wordData,
  input  logic                extClear,
  input  logic                trigOnFull,
  input  logic                variantSel,
  input  logic [SERIAL_W-1:0] serialNum,
  output logic [LEVEL_W-1:0]  irqLevel,
  output logic [VEC_W-1:0]    irqVector,
  output logic [DAC_W-1:0]    dacLevel,
  output logic                testGate,
  output logic                clearPulse
);
  localparam int DEPTH = EVENTS * CHANNELS * RANGES;

  ctlStrobe_t str;
  logic       fifoRdy, fifoFull;

  evb_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .busStb(busStb), .busWe(busWe),
    .busAddr(busAddr), .extClear(extClear), .str(str),
    .busAck(busAck), .testGate(testGate), .clearPulse(clearPulse)
  );

  evb_data #(.DEPTH(DEPTH)) uData (
    .clk(clk), .rstN(rstN), .str(str), .busWdata(busWdata),
    .wordValid(wordValid), .wordData(wordData), .trigOnFull(trigOnFull),
    .variantSel(variantSel), .serialNum(serialNum), .busRdata(busRdata),
    .fifoRdy(fifoRdy), .fifoFull(fifoFull), .irqLevel(irqLevel),
    .irqVector(irqVector), .dacLevel(dacLevel)
  );
endmodule

// File: rtl/evb_checker.sv
module evb_checker (
  input logic       clk,
  input logic       rstN,
  input logic       busStb,
  input logic       busAck,
  input logic       extClear,
  input logic       trigOnFull,
  input logic       fifoRdy,
  input logic       fifoFull,
  input logic [2:0] irqLevel,
  input logic       testGate,
  input logic       clearPulse
);
  p_ack_follows_r1: assert property (@(posedge clk) disable iff (!rstN)
    (busStb && !busAck) |=> busAck);
  p_ack_single_r1: assert property (@(posedge clk) disable iff (!rstN)
    busAck |=> !busAck);
  p_full_has_rdy_r2: assert property (@(posedge clk) disable iff (!rstN)
    fifoFull |-> fifoRdy);
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rstN)
    (fifoFull && !busStb && !extClear) |=> fifoFull);
  p_irq_needs_cond_r5: assert property (@(posedge clk) disable iff (!rstN)
    (irqLevel != 3'd0) |-> (trigOnFull ? fifoFull : fifoRdy));
  p_irq_release_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!trigOnFull && !fifoRdy) |-> (irqLevel == 3'd0));
  p_clear_empties_r7: assert property (@(posedge clk) disable iff (!rstN)
    extClear |=> (!fifoRdy && clearPulse));
  p_gate_one_shot_r9: assert property (@(posedge clk) disable iff (!rstN)
    testGate |=> !testGate);
endmodule

bind evb_regfile evb_checker uChk (
  .clk(clk), .rstN(rstN), .busStb(busStb), .busAck(busAck),
  .extClear(extClear), .trigOnFull(trigOnFull), .fifoRdy(fifoRdy),
  .fifoFull(fifoFull), .irqLevel(irqLevel), .testGate(testGate),
  .clearPulse(clearPulse)
);

// File: tb/sim_evb_regfile.sv
module sim_evb_regfile;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;
  // {we, req, addr, wdata, expected read}
  localparam logic [44:0] VECS [NVEC] = '{
    {1'b1, 4'd4,  8'h00, 16'hFFFF, 16'h0000},
    {1'b0, 4'd4,  8'h00, 16'h0000, 16'h07FF}, // R4 bits 15:11 dropped
    {1'b1, 4'd4,  8'h00, 16'h0000, 16'h0000},
    {1'b0, 4'd4,  8'h00, 16'h0000, 16'h0000},
    {1'b1, 4'd8,  8'h04, 16'hF123, 16'h0000},
    {1'b0, 4'd8,  8'h04, 16'h0000, 16'h0000}, // R8 read is zero
    {1'b0, 4'd10, 8'hFE, 16'h0000, 16'h12A5}, // R10 identification
    {1'b1, 4'd11, 8'h0A, 16'h5555, 16'h0000},
    {1'b0, 4'd11, 8'h0A, 16'h0000, 16'h0000}, // R11 unmapped
    {1'b0, 4'd3,  8'h08, 16'h0000, 16'h0000}, // R3 empty read after reset
    {1'b1, 4'd4,  8'h00, 16'h0342, 16'h0000},
    {1'b0, 4'd4,  8'h00, 16'h0000, 16'h0342}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busStb = 1'b0, busWe = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [15:0] busWdata = '0, busRdata;
  logic        busAck;
  logic        wordValid = 1'b0;
  logic [15:0] wordData = '0;
  logic        extClear = 1'b0, trigOnFull = 1'b0;
  logic        variantSel = 1'b1;
  logic [11:0] serialNum = 12'h2A5;
  logic [2:0]  irqLevel;
  logic [7:0]  irqVector;
  logic [11:0] dacLevel;
  logic        testGate, clearPulse;

  int checks = 0, fails = 0;
  logic [15:0] rd;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evb_regfile u0 (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [7:0] addr,
                        input logic [15:0] wd, output logic [15:0] rdo);
    @(negedge clk);
    busStb = 1'b1; busWe = we; busAddr = addr; busWdata = wd;
    @(negedge clk);
    busStb = 1'b0; busWe = 1'b0;
    rdo = busRdata;
    chk("R1 ack", 16'(busAck), 16'd1);
  endtask

  task automatic push(input logic [15:0] d);
    @(negedge clk);
    wordValid = 1'b1; wordData = d;
    @(negedge clk);
    wordValid = 1'b0;
  endtask

  task automatic finishRun();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    // reset state
    chk("R1 reset ack", 16'(busAck), 16'd0);
    chk("R5 reset irq", 16'(irqLevel), 16'd0);
    chk("R8 reset dac", 16'(dacLevel), 16'd0);
    chk("R9 reset gate", 16'(testGate), 16'd0);

    for (int i = 0; i < NVEC; i++) begin
      access(VECS[i][44], VECS[i][39:32], VECS[i][31:16], rd);
      if (!VECS[i][44]) chk($sformatf("R%0d vec%0d", VECS[i][43:40], i), rd, VECS[i][15:0]);
    end
    @(negedge clk);
    chk("R1 ack drops", 16'(busAck), 16'd0);
    chk("R8 dac value", 16'(dacLevel), 16'h0123);
    chk("R11 dac kept after unmapped write", 16'(dacLevel), 16'h0123);

    // not-empty interrupt, level 3 vector 42
    chk("R5 irq idle when empty", 16'(irqLevel), 16'd0);
    push(16'hA001); push(16'hA002); push(16'hA003);
    chk("R5 irq level", 16'(irqLevel), 16'd3);
    chk("R5 irq vector", 16'(irqVector), 16'h0042);
    access(1'b0, 8'h00, 16'h0, rd); chk("R4 status ready", rd, 16'h8342);
    access(1'b0, 8'h08, 16'h0, rd); chk("R3 first", rd, 16'hA001);
    access(1'b0, 8'h08, 16'h0, rd); chk("R3 second", rd, 16'hA002);
    chk("R5 irq still up", 16'(irqLevel), 16'd3);
    access(1'b0, 8'h08, 16'h0, rd); chk("R3 third", rd, 16'hA003);
    chk("R6 irq drops on empty", 16'(irqLevel), 16'd0);
    access(1'b0, 8'h08, 16'h0, rd); chk("R3 empty repeats last", rd, 16'hA003);
    access(1'b0, 8'h00, 16'h0, rd); chk("R4 status empty", rd, 16'h0342);

    // fill beyond capacity
    for (int i = 0; i < 257; i++) push(16'h1000 + 16'(i));
    access(1'b0, 8'h00, 16'h0, rd); chk("R2 status full", rd, 16'hC342);
    @(negedge clk) trigOnFull = 1'b1;
    #1 chk("R5 irq on full", 16'(irqLevel), 16'd3);
    access(1'b0, 8'h08, 16'h0, rd); chk("R3 oldest of full", rd, 16'h1000);
    chk("R6 irq drops off full", 16'(irqLevel), 16'd0);
    begin
      int bad = 0;
      for (int i = 1; i < 256; i++) begin
        access(1'b0, 8'h08, 16'h0, rd);
        if (rd !== 16'h1000 + 16'(i)) bad++;
      end
      chk("R2 sequence intact", 16'(bad), 16'd0);
    end
    access(1'b0, 8'h08, 16'h0, rd); chk("R2 extra word dropped", rd, 16'h10FF);
    @(negedge clk) trigOnFull = 1'b0;

    // test gate
    access(1'b1, 8'h06, 16'h0, rd);
    chk("R9 gate high", 16'(testGate), 16'd1);
    @(negedge clk) chk("R9 gate one cycle", 16'(testGate), 16'd0);

    // bus clear
    push(16'h2222); push(16'h3333);
    access(1'b0, 8'h02, 16'h0, rd);
    chk("R7 clear pulse", 16'(clearPulse), 16'd1);
    access(1'b0, 8'h00, 16'h0, rd); chk("R7 status cleared", rd, 16'h0000);
    chk("R7 dac cleared", 16'(dacLevel), 16'd0);
    chk("R7 pulse single", 16'(clearPulse), 16'd0);

    // external clear
    access(1'b1, 8'h00, 16'h0155, rd);
    push(16'h4444);
    chk("R5 irq level 1", 16'(irqLevel), 16'd1);
    @(negedge clk) extClear = 1'b1;
    @(negedge clk) extClear = 1'b0;
    chk("R7 ext clear pulse", 16'(clearPulse), 16'd1);
    chk("R7 ext clear irq", 16'(irqLevel), 16'd0);
    access(1'b0, 8'h00, 16'h0, rd); chk("R7 ext clear status", rd, 16'h0000);

    // write to data offset ignored
    push(16'hBEEF);
    access(1'b1, 8'h08, 16'h1111, rd);
    access(1'b0, 8'h08, 16'h0, rd); chk("R3 data write ignored", rd, 16'hBEEF);

    done = 1;
    finishRun();
  end
endmodule